// File: doc/BRIEF.md
# Banked system-control register file with per-copy write masks

This block holds the system-control registers of a small multithreaded core. A register is named by a flat 8-bit index, with the register number in the upper five bits and the select value in the lower three (index = number × 8 + select). Each implemented register falls into one of three bank classes. A shared register has a single copy for the whole core. An element register has one copy for each virtual processing element. A thread register has one copy for each thread context. Each copy carries its own 32-bit write mask.

Every access presents a thread ID. A thread register is banked directly by that ID. An element register is banked by the element field of the requesting thread's own binding register. Normal writes pass through the mask, so read-only fields keep their value. A raw write path stores the whole word, and a mask path loads the copy's mask. Reset gives each copy its default value and mask.

Top module: `creg_file`

## Requirements
- R1: The implemented indices are as follows. Shared: 2 mt_cfg, 8 random, 97 int_ctl, 98 shadow_ctl, 120 proc_id, 121 exc_base, 128–131 cfg0–cfg3. Element: 9 elem_ctl, 10 elem_cfg. Thread: 17 thr_state, 18 thr_bind, 20 thr_halt, 96 status, 136 ll_addr. Any other index reads zero, and writes to it change nothing.
- R2: A thread register access uses the copy that belongs to `thread_i`. A write from one thread leaves the other threads' copies unchanged.
- R3: An element register access uses the copy of the element held in bits [3:0] of the requesting thread's thr_bind. If that element number is N_ELEMS or more, the access reads zero and its write is ignored.
- R4: A filtered write (`we_i`) stores (wdata & mask) | (old & ~mask).
- R5: A raw write (`raw_we_i`) stores all 32 bits of `wdata_i`, whatever the mask holds. It takes priority over `we_i`.
- R6: A mask write (`mask_we_i`) loads `wdata_i` into the mask of the selected copy and leaves its value unchanged. It takes priority over both value writes.
- R7: The reset masks are 0 for mt_cfg, random, proc_id, cfg1 and cfg3. cfg0 resets to 0x7FFF0007, cfg2 to 0x7000F000, exc_base to 0x3FFFF000, shadow_ctl to 0x0000F3C0, int_ctl to 0x000003E0 and status to 0xFF78FF17. All other masks reset to all ones.
- R8: The reset values are: random = 63; exc_base = 0x80000000; status = 0x10400004 (bits 28, 22 and 2 set); proc_id = PROC_ID; mt_cfg with N_THREADS−1 in bits [7:0] and N_ELEMS−1 in bits [13:10]. Every other copy resets to 0.
- R9: A `thread_i` of N_THREADS or more reads zero, and its writes change no copy.
- R10: `rdata_o` is registered. It shows the addressed copy one cycle after the request, with the value held before any write in that same cycle, and it is zero out of reset.
- R11: A shared register has one copy. A write from any thread is seen by every thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thread_i | input | THR_W | Requesting thread ID |
| index_i | input | 8 | Flat register index (number × 8 + select) |
| we_i | input | 1 | Filtered (masked) write enable |
| raw_we_i | input | 1 | Unmasked write enable |
| mask_we_i | input | 1 | Write enable for the copy's mask |
| wdata_i | input | 32 | Write data for value or mask |
| rdata_o | output | 32 | Registered read data |

## Verification
The hardest case is an element register reached through a binding that has just changed. The same index must land on a different copy once a thread's thr_bind is rewritten, and it must land on no copy when the bound element is out of range. The random stimulus rewrites thr_bind with small element numbers, some of them beyond the last element, in between element-register accesses from every thread. Directed steps first bind two threads to different elements and to an invalid one. Mask writes appear in the random mix, so filtered writes are tried against masks other than the reset set.

// File: rtl/creg_pkg.sv
package creg_pkg;
  typedef enum logic [1:0] {CLS_NONE, CLS_SHARED, CLS_ELEM, CLS_THREAD} cls_e;

  localparam int N_SH = 10;
  localparam int N_EL = 2;
  localparam int N_TH = 5;
  localparam int BIND_SLOT   = 1;
  localparam int STATUS_SLOT = 3;
  localparam int ELEM_FW     = 4;

  function automatic logic [31:0] shared_mask(int slot);
    case (slot)
      2:       return 32'h0000_03E0;
      3:       return 32'h0000_F3C0;
      5:       return 32'h3FFF_F000;
      6:       return 32'h7FFF_0007;
      7:       return 32'h0000_0000;
      8:       return 32'h7000_F000;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] shared_val(int slot, int nthr, int nelem, logic [31:0] pid);
    case (slot)
      0:       return 32'((nelem - 1) << 10) | 32'(nthr - 1);
      1:       return 32'd63;
      4:       return pid;
      5:       return 32'h8000_0000;
      default: return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/creg_decode.sv
module creg_decode
  import creg_pkg::*;
(
  input  logic [7:0] index_i,
  output cls_e       cls_o,
  output logic [3:0] slot_o
);
  always_comb begin
    cls_o  = CLS_NONE;
    slot_o = '0;
    case (index_i)
      8'd2:   begin cls_o = CLS_SHARED; slot_o = 4'd0; end
      8'd8:   begin cls_o = CLS_SHARED; slot_o = 4'd1; end
      8'd97:  begin cls_o = CLS_SHARED; slot_o = 4'd2; end
      8'd98:  begin cls_o = CLS_SHARED; slot_o = 4'd3; end
      8'd120: begin cls_o = CLS_SHARED; slot_o = 4'd4; end
      8'd121: begin cls_o = CLS_SHARED; slot_o = 4'd5; end
      8'd128: begin cls_o = CLS_SHARED; slot_o = 4'd6; end
      8'd129: begin cls_o = CLS_SHARED; slot_o = 4'd7; end
      8'd130: begin cls_o = CLS_SHARED; slot_o = 4'd8; end
      8'd131: begin cls_o = CLS_SHARED; slot_o = 4'd9; end
      8'd9:   begin cls_o = CLS_ELEM;   slot_o = 4'd0; end
      8'd10:  begin cls_o = CLS_ELEM;   slot_o = 4'd1; end
      8'd17:  begin cls_o = CLS_THREAD; slot_o = 4'd0; end
      8'd18:  begin cls_o = CLS_THREAD; slot_o = 4'd1; end
      8'd20:  begin cls_o = CLS_THREAD; slot_o = 4'd2; end
      8'd96:  begin cls_o = CLS_THREAD; slot_o = 4'd3; end
      8'd136: begin cls_o = CLS_THREAD; slot_o = 4'd4; end
      default: ;
    endcase
  end
endmodule

// File: rtl/creg_word.sv
module creg_word #(
  parameter logic [31:0] RST_VAL  = 32'h0,
  parameter logic [31:0] RST_MASK = 32'hFFFF_FFFF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_i,
  input  logic        we_i,
  input  logic        raw_i,
  input  logic        mwe_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] q_o
);
  logic [31:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o    <= RST_VAL;
      mask_q <= RST_MASK;
    end else if (sel_i) begin
      if (mwe_i)      mask_q <= wdata_i;
      else if (raw_i) q_o    <= wdata_i;
      else if (we_i)  q_o    <= (wdata_i & mask_q) | (q_o & ~mask_q);
    end
  end

  AST_RO_BITS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && we_i && !raw_i && !mwe_i |=> ((q_o ^ $past(q_o)) & ~$past(mask_q)) == 32'h0); // R4
  AST_RW_BITS_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && we_i && !raw_i && !mwe_i |=> ((q_o ^ $past(wdata_i)) & $past(mask_q)) == 32'h0); // R4
  AST_RAW_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && raw_i && !mwe_i |=> q_o == $past(wdata_i)); // R5
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i && mwe_i |=> mask_q == $past(wdata_i) && $stable(q_o)); // R6
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(q_o) && $stable(mask_q)); // R9
endmodule

// File: rtl/creg_file.sv
module creg_file
  import creg_pkg::*;
#(
  parameter int          N_THREADS = 3,
  parameter int          N_ELEMS   = 2,
  parameter int          THR_W     = 3,
  parameter logic [31:0] PROC_ID   = 32'h0001_8A01
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [THR_W-1:0] thread_i,
  input  logic [7:0]       index_i,
  input  logic             we_i,
  input  logic             raw_we_i,
  input  logic             mask_we_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  localparam int EL_BASE = N_SH;
  localparam int TH_BASE = N_SH + N_EL * N_ELEMS;
  localparam int NCOPY   = TH_BASE + N_TH * N_THREADS;
  localparam int BIND_C0 = TH_BASE + BIND_SLOT * N_THREADS;

  cls_e               cls;
  logic [3:0]         slot;
  logic [31:0]        q_w [NCOPY];
  logic [NCOPY-1:0]   sel;
  logic [31:0]        bind_w, rd_d;
  logic [ELEM_FW-1:0] elem_id;
  logic               thr_ok, elem_ok, hit;
  int                 copy_n;

  creg_decode u_dec (.index_i(index_i), .cls_o(cls), .slot_o(slot));

  always_comb begin
    thr_ok = int'(thread_i) < N_THREADS;
    bind_w = '0;
    for (int t = 0; t < N_THREADS; t++)
      if (int'(thread_i) == t) bind_w = q_w[BIND_C0 + t];
    elem_id = bind_w[ELEM_FW-1:0];
    elem_ok = int'(elem_id) < N_ELEMS;
    case (cls)
      CLS_SHARED: copy_n = int'(slot);
      CLS_ELEM:   copy_n = EL_BASE + int'(slot) * N_ELEMS + int'(elem_id);
      CLS_THREAD: copy_n = TH_BASE + int'(slot) * N_THREADS + int'(thread_i);
      default:    copy_n = NCOPY;
    endcase
    hit = thr_ok && (cls != CLS_NONE) && (cls != CLS_ELEM || elem_ok);
  end

  for (genvar c = 0; c < NCOPY; c++) begin : g_copy
    localparam bit IS_SH = c < EL_BASE;
    localparam bit IS_EL = !IS_SH && c < TH_BASE;
    localparam int SLOT  = IS_SH ? c : IS_EL ? (c - EL_BASE) / N_ELEMS : (c - TH_BASE) / N_THREADS;
    localparam logic [31:0] RV = IS_SH ? shared_val(SLOT, N_THREADS, N_ELEMS, PROC_ID) :
                                 (!IS_EL && SLOT == STATUS_SLOT) ? 32'h1040_0004 : 32'h0;
    localparam logic [31:0] RM = IS_SH ? shared_mask(SLOT) :
                                 (!IS_EL && SLOT == STATUS_SLOT) ? 32'hFF78_FF17 : 32'hFFFF_FFFF;

    assign sel[c] = hit && (copy_n == c);

    creg_word #(.RST_VAL(RV), .RST_MASK(RM)) u_word (
      .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel[c]),
      .we_i(we_i), .raw_i(raw_we_i), .mwe_i(mask_we_i),
      .wdata_i(wdata_i), .q_o(q_w[c])
    );
  end

  always_comb begin
    rd_d = '0;
    for (int c = 0; c < NCOPY; c++)
      if (sel[c]) rd_d = rd_d | q_w[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_d;
  end

  AST_ONE_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel)); // R2
  AST_BAD_THREAD_RDZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(thread_i) >= N_THREADS |=> rdata_o == 32'h0); // R9
  AST_UNMAPPED_RDZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls == CLS_NONE |=> rdata_o == 32'h0); // R1
  AST_ELEM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cls == CLS_ELEM && !elem_ok |=> rdata_o == 32'h0); // R3
endmodule

// File: tb/creg_file_test.sv
`timescale 1ns/1ps
module creg_file_test;
  localparam int T = 3;
  localparam int E = 2;
  localparam int NC = 10 + 2 * E + 5 * T;
  localparam logic [31:0] PID = 32'h0001_8A01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  thr = '0;
  logic [7:0]  idx = '0;
  logic        we = 1'b0, raw = 1'b0, mwe = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rd;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mv [NC];
  logic [31:0] mm [NC];
  int regs [17] = '{2, 8, 97, 98, 120, 121, 128, 129, 130, 131, 9, 10, 17, 18, 20, 96, 136};

  always #2.5 clk = ~clk;

  creg_file #(.N_THREADS(T), .N_ELEMS(E), .THR_W(3), .PROC_ID(PID)) uut (
    .clk_i(clk), .rst_ni(rst_n), .thread_i(thr), .index_i(idx),
    .we_i(we), .raw_we_i(raw), .mask_we_i(mwe), .wdata_i(wd), .rdata_o(rd));

  // class: 0 none, 1 shared, 2 element, 3 thread (R1 table)
  function automatic void dec(input int i, output int cls, output int slot);
    cls = 0; slot = 0;
    case (i)
      2: begin cls = 1; slot = 0; end    8: begin cls = 1; slot = 1; end
      97: begin cls = 1; slot = 2; end   98: begin cls = 1; slot = 3; end
      120: begin cls = 1; slot = 4; end  121: begin cls = 1; slot = 5; end
      128: begin cls = 1; slot = 6; end  129: begin cls = 1; slot = 7; end
      130: begin cls = 1; slot = 8; end  131: begin cls = 1; slot = 9; end
      9: begin cls = 2; slot = 0; end    10: begin cls = 2; slot = 1; end
      17: begin cls = 3; slot = 0; end   18: begin cls = 3; slot = 1; end
      20: begin cls = 3; slot = 2; end   96: begin cls = 3; slot = 3; end
      136: begin cls = 3; slot = 4; end
      default: ;
    endcase
  endfunction

  function automatic bit copy_of(input int t, input int i, output int c, output string tag);
    int cls, slot, e;
    c = 0;
    dec(i, cls, slot);
    if (t >= T) begin tag = "R9"; return 0; end
    case (cls)
      1: begin tag = "R11"; c = slot; return 1; end
      2: begin
        tag = "R3";
        e = int'(mv[10 + 2 * E + T + t][3:0]);
        if (e >= E) return 0;
        c = 10 + slot * E + e; return 1;
      end
      3: begin tag = "R2"; c = 10 + 2 * E + slot * T + t; return 1; end
      default: begin tag = "R1"; return 0; end
    endcase
  endfunction

  task automatic model_reset();
    for (int c = 0; c < NC; c++) begin mv[c] = '0; mm[c] = '1; end
    mv[0] = 32'h0000_0402; mm[0] = '0;
    mv[1] = 32'd63;        mm[1] = '0;
    mm[2] = 32'h0000_03E0; mm[3] = 32'h0000_F3C0;
    mv[4] = PID;           mm[4] = '0;
    mv[5] = 32'h8000_0000; mm[5] = 32'h3FFF_F000;
    mm[6] = 32'h7FFF_0007; mm[7] = '0; mm[8] = 32'h7000_F000; mm[9] = '0;
    for (int t = 0; t < T; t++) begin
      mv[10 + 2 * E + 3 * T + t] = 32'h1040_0004;
      mm[10 + 2 * E + 3 * T + t] = 32'hFF78_FF17;
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; we = 0; raw = 0; mwe = 0;
    repeat (2) @(negedge clk);
    model_reset();
    checks++;
    if (rd !== 32'h0) begin
      errors++;
      $display("FAIL R10 rdata after reset act=%h exp=%h", rd, 32'h0);
    end
    rst_n = 1'b1;
  endtask

  // kind: 0 read, 1 filtered write, 2 raw write, 3 mask write
  task automatic op(input int t, input int i, input int kind, input logic [31:0] d, input string tg);
    int c;
    string tag;
    bit ok;
    logic [31:0] exp;
    ok = copy_of(t, i, c, tag);
    if (tg != "") tag = tg;
    exp = ok ? mv[c] : 32'h0;
    @(negedge clk);
    thr = 3'(t); idx = 8'(i); wd = d;
    we = (kind == 1); raw = (kind == 2); mwe = (kind == 3);
    @(posedge clk);
    #1;
    checks++;
    if (rd !== exp) begin
      errors++;
      $display("FAIL %s t=%0d idx=%0d act=%h exp=%h", tag, t, i, rd, exp);
    end
    if (ok) begin
      if (kind == 3)      mm[c] = d;
      else if (kind == 2) mv[c] = d;
      else if (kind == 1) mv[c] = (d & mm[c]) | (mv[c] & ~mm[c]);
    end
    @(negedge clk);
    we = 0; raw = 0; mwe = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    apply_reset();
    // R8: reset values, every register from every thread
    for (int t = 0; t < T; t++)
      foreach (regs[k]) op(t, regs[k], 0, '0, "R8");
    // R7: all-ones filtered write exposes each reset mask
    foreach (regs[k]) op(0, regs[k], 1, 32'hFFFF_FFFF, "R7");
    foreach (regs[k]) op(0, regs[k], 0, '0, "R7");
    op(1, 96, 1, 32'h0000_0000, "R7");
    op(1, 96, 0, '0, "R7");
    // R5, R10: raw write returns old value that cycle, new value next
    op(0, 136, 2, 32'hDEAD_BEEF, "R10");
    op(0, 136, 0, '0, "R5");
    op(0, 8, 2, 32'h0000_0011, "R5");
    op(2, 8, 0, '0, "R5");
    // R2: per-thread copies are independent
    op(1, 136, 2, 32'h1234_5678, "R2");
    op(0, 136, 0, '0, "R2");
    op(1, 136, 0, '0, "R2");
    // R11: shared copy seen from every thread
    op(0, 98, 2, 32'hA5A5_0000, "R11");
    op(2, 98, 0, '0, "R11");
    // R3: binding steers element copies, out-of-range element ignored
    op(1, 18, 2, 32'h1, "R3");
    op(1, 9, 2, 32'hCAFE_0001, "R3");
    op(0, 9, 0, '0, "R3");
    op(1, 9, 0, '0, "R3");
    op(2, 18, 2, 32'h5, "R3");
    op(2, 9, 2, 32'hFFFF_FFFF, "R3");
    op(2, 9, 0, '0, "R3");
    op(1, 9, 0, '0, "R3");
    // R9: out-of-range thread
    op(5, 136, 2, 32'h5555_5555, "R9");
    op(5, 136, 0, '0, "R9");
    op(7, 121, 0, '0, "R9");
    // R1: unmapped index
    op(0, 3, 2, 32'hFFFF_FFFF, "R1");
    op(0, 3, 0, '0, "R1");
    // R6, R4: loaded mask governs later filtered writes
    op(0, 136, 3, 32'h0000_FFFF, "R6");
    op(0, 136, 0, '0, "R6");
    op(0, 136, 1, 32'h0000_0000, "R4");
    op(0, 136, 0, '0, "R4");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int t, i, k, r;
      logic [31:0] d;
      t = ($urandom % 8 < 7) ? int'($urandom % T) : int'($urandom % 8);
      i = ($urandom % 5 != 0) ? regs[$urandom % 17] : int'($urandom % 256);
      r = int'($urandom % 20);
      k = (r < 8) ? 0 : (r < 14) ? 1 : (r < 19) ? 2 : 3;
      d = $urandom;
      if (i == 18) begin d = 32'($urandom % 4); if (k == 3) k = 2; end
      op(t, i, k, d, "");
    end
    // R8: second reset restores defaults
    apply_reset();
    for (int t = 0; t < T; t++)
      foreach (regs[k]) op(t, regs[k], 0, '0, "R8");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule